// File: doc/BRIEF.md
# Synchronous Serial Shift Port

This block moves one byte at a time over a three-wire synchronous serial link. A shift register is sent out most significant bit first on the serial output, and the bits that arrive on the serial input are shifted in behind it. When the exchange ends, the register holds the received byte. Software loads the register, chooses the pin mode and clock rate, and then writes the busy flag to 1 to start a transfer. Hardware clears busy after the last bit. Software may also clear busy itself partway through, which ends a shorter transfer.

Two independent configuration bits set the pin roles. The first chooses whether the serial output is driven or left tri-stated. The second chooses whether the shift clock is made inside the block (master) or taken from the clock pin (slave). Together they give four master and slave modes. A master-enable bit gates the whole port. In master mode, a divider derived from the instruction cycle sets the clock period to 2, 4 or 8 instruction cycles. In slave mode, the external clock is resynchronised to the system clock and its edges are detected. For this reason the system clock must run at least four times faster than the external clock.

Top module: `sio_port`

## Requirements
- R1: After reset, busy, the generated clock, the interrupt, the received byte and both output enables are all 0.
- R2: The serial output enable equals enable AND drive-select. The clock output enable equals enable AND internal-clock-select. With enable at 0, both enables stay low whatever the other two bits are.
- R3: In master mode, each high phase of the generated clock lasts TC_CLKS system clocks when the rate field is 00, 2*TC_CLKS when it is 01, and 4*TC_CLKS when it is 10 or 11. The low phase has the same length, so one clock period is 2, 4 or 8 instruction cycles.
- R4: Data leaves most significant bit first. The output bit changes on the falling clock edge and the input bit is sampled on the rising edge. The clock idles low whenever busy is 0.
- R5: Writing busy to 1 from idle starts a transfer. In master mode exactly eight clock pulses follow, and then hardware clears busy.
- R6: When the interrupt enable is set, a full eight-bit transfer raises the interrupt output for exactly one cycle, in the cycle where busy falls. When the interrupt enable is clear, no interrupt is raised.
- R7: Writing busy to 0 during a transfer stops the clock at once and raises no interrupt. The register keeps the partly shifted byte: after k bits it holds the original low bits followed by the k received bits.
- R8: In slave mode the block shifts on the edges of the external clock, seen through a two-flop synchronizer. After eight external falling edges it clears busy and holds the master's byte.
- R9: With enable at 0, external clock edges and a pending busy flag shift nothing, and the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration fields below |
| cfg_enable | input | 1 | Master enable for the port |
| cfg_drive_so | input | 1 | 1 drives the serial output, 0 leaves it tri-stated |
| cfg_int_clk | input | 1 | 1 selects the internal clock (master), 0 the external clock (slave) |
| cfg_rate | input | 2 | Master clock period: 00 = 2, 01 = 4, 1x = 8 instruction cycles |
| cfg_irq_en | input | 1 | Enables the completion interrupt |
| dat_we | input | 1 | Write strobe for the shift register |
| dat_wdata | input | DW | Shift register load value |
| busy_we | input | 1 | Write strobe for the busy flag |
| busy_wdata | input | 1 | Busy value to write |
| sin | input | 1 | Serial data input |
| sk_in | input | 1 | External shift clock |
| so | output | 1 | Serial data output |
| so_oe | output | 1 | Serial output driver enable |
| sk_out | output | 1 | Generated shift clock |
| sk_oe | output | 1 | Clock pin output enable |
| busy | output | 1 | Transfer in progress |
| rx_data | output | DW | Shift register contents |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The bench builds two copies with DW = 8 and TC_CLKS = 4. One is a master and the other a slave, and each one's output is looped into the other's input. With a four-cycle instruction period, the shortest half period is four system clocks. That is just longer than the slave's three-cycle synchronizer and edge latency, so the tightest master-to-slave timing is exercised on every exchange at rate 00. The longer rates reach 16 system clocks per half period, which keeps each byte within a few hundred cycles. This leaves room to walk all four rate codes, an early abort after three bits, and a slave left disabled while its master clocks it.

// File: rtl/sio_port.sv
module sio_port #(
  parameter int DW      = 8,
  parameter int TC_CLKS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_enable,
  input  logic          cfg_drive_so,
  input  logic          cfg_int_clk,
  input  logic [1:0]    cfg_rate,
  input  logic          cfg_irq_en,
  input  logic          dat_we,
  input  logic [DW-1:0] dat_wdata,
  input  logic          busy_we,
  input  logic          busy_wdata,
  input  logic          sin,
  input  logic          sk_in,
  output logic          so,
  output logic          so_oe,
  output logic          sk_out,
  output logic          sk_oe,
  output logic          busy,
  output logic [DW-1:0] rx_data,
  output logic          irq
);
  localparam int HW = $clog2(4 * TC_CLKS + 1);
  localparam int CW = $clog2(DW + 1);

  logic          en_q, drv_q, int_q, irq_en_q;
  logic [1:0]    rate_q;
  logic [DW-1:0] sr_q;
  logic          in_q, sck_q, busy_q, irq_q;
  logic [HW-1:0] div_q, half;
  logic [CW-1:0] bit_q;
  logic [2:0]    sync_q;

  always_comb begin
    case (rate_q)
      2'b00:   half = HW'(TC_CLKS);
      2'b01:   half = HW'(2 * TC_CLKS);
      default: half = HW'(4 * TC_CLKS);
    endcase
  end

  wire run      = busy_q & en_q & ~busy_we;
  wire tick     = run & int_q & (div_q == half - 1'b1);
  wire ext_rise = sync_q[1] & ~sync_q[2];
  wire ext_fall = ~sync_q[1] & sync_q[2];
  wire rise_ev  = run & (int_q ? (tick & ~sck_q) : ext_rise);
  wire fall_ev  = run & (int_q ? (tick & sck_q) : ext_fall);
  wire last     = fall_ev & (bit_q == CW'(DW - 1));
  wire start    = busy_we & busy_wdata & ~busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; drv_q <= 1'b0; int_q <= 1'b0; rate_q <= 2'b00; irq_en_q <= 1'b0;
    end else if (cfg_we) begin
      en_q <= cfg_enable; drv_q <= cfg_drive_so; int_q <= cfg_int_clk;
      rate_q <= cfg_rate; irq_en_q <= cfg_irq_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], sk_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; sck_q <= 1'b0; irq_q <= 1'b0; in_q <= 1'b0;
      div_q <= '0; bit_q <= '0;
    end else begin
      irq_q <= 1'b0;
      if (busy_we) begin
        busy_q <= busy_wdata;
        if (!busy_wdata) sck_q <= 1'b0;
        if (start) begin
          div_q <= '0; bit_q <= '0; sck_q <= 1'b0;
        end
      end else begin
        if (!en_q) sck_q <= 1'b0;
        if (run && int_q) div_q <= tick ? '0 : div_q + 1'b1;
        if (tick) sck_q <= ~sck_q;
        if (rise_ev) in_q <= sin;
        if (fall_ev) bit_q <= bit_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0; irq_q <= irq_en_q; bit_q <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr_q <= '0;
    else if (dat_we)  sr_q <= dat_wdata;
    else if (fall_ev) sr_q <= {sr_q[DW-2:0], in_q};
  end

  assign so      = sr_q[DW-1];
  assign so_oe   = en_q & drv_q;
  assign sk_out  = sck_q;
  assign sk_oe   = en_q & int_q;
  assign busy    = busy_q;
  assign rx_data = sr_q;
  assign irq     = irq_q;

  p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sck_q);
  p_irq_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $fell(busy_q));
  p_bit_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q <= CW'(DW - 1));
  p_clk_master_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_q) |-> $past(int_q) && $past(busy_q));
  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_we && !busy_wdata) |=> !busy_q && !irq_q && !sck_q);
  p_off_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !dat_we) |=> $stable(sr_q));
endmodule

// File: tb/sio_port_bench.sv
module sio_port_bench;
  localparam int TC = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  // cfg vector: {enable, drive_so, int_clk, rate[1:0], irq_en}
  logic [5:0] m_cfg = '0, s_cfg = '0;
  logic m_cfg_we = 0, s_cfg_we = 0, m_dwe = 0, s_dwe = 0;
  logic [7:0] m_dw = '0, s_dw = '0;
  logic m_bwe = 0, m_bv = 0, s_bwe = 0, s_bv = 0;
  logic m_so, m_so_oe, m_sk, m_sk_oe, m_busy, m_irq;
  logic s_so, s_so_oe, s_sk, s_sk_oe, s_busy, s_irq;
  logic [7:0] m_rx, s_rx;

  sio_port #(.DW(8), .TC_CLKS(TC)) u_sio_port (
    .clk(clk), .rst_n(rst_n), .cfg_we(m_cfg_we), .cfg_enable(m_cfg[5]),
    .cfg_drive_so(m_cfg[4]), .cfg_int_clk(m_cfg[3]), .cfg_rate(m_cfg[2:1]),
    .cfg_irq_en(m_cfg[0]), .dat_we(m_dwe), .dat_wdata(m_dw), .busy_we(m_bwe),
    .busy_wdata(m_bv), .sin(s_so), .sk_in(1'b0), .so(m_so), .so_oe(m_so_oe),
    .sk_out(m_sk), .sk_oe(m_sk_oe), .busy(m_busy), .rx_data(m_rx), .irq(m_irq));

  sio_port #(.DW(8), .TC_CLKS(TC)) u_sio_port_slave (
    .clk(clk), .rst_n(rst_n), .cfg_we(s_cfg_we), .cfg_enable(s_cfg[5]),
    .cfg_drive_so(s_cfg[4]), .cfg_int_clk(s_cfg[3]), .cfg_rate(s_cfg[2:1]),
    .cfg_irq_en(s_cfg[0]), .dat_we(s_dwe), .dat_wdata(s_dw), .busy_we(s_bwe),
    .busy_wdata(s_bv), .sin(m_so), .sk_in(m_sk), .so(s_so), .so_oe(s_so_oe),
    .sk_out(s_sk), .sk_oe(s_sk_oe), .busy(s_busy), .rx_data(s_rx), .irq(s_irq));

  int n_chk = 0, n_err = 0;
  int n_rise = 0, n_fall = 0, n_hi = 0, n_irq_m = 0, n_irq_s = 0;
  logic mon_prev = 1'b0;

  always @(negedge clk) begin
    if (m_sk && !mon_prev) n_rise++;
    if (!m_sk && mon_prev) n_fall++;
    if (m_sk) n_hi++;
    if (m_irq) n_irq_m++;
    if (s_irq) n_irq_s++;
    mon_prev = m_sk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr_cfg(input logic [5:0] mc, input logic [5:0] sc);
    m_cfg = mc; s_cfg = sc; m_cfg_we = 1; s_cfg_we = 1;
    step();
    m_cfg_we = 0; s_cfg_we = 0;
  endtask

  task automatic load(input logic [7:0] md, input logic [7:0] sd);
    m_dw = md; s_dw = sd; m_dwe = 1; s_dwe = 1;
    step();
    m_dwe = 0; s_dwe = 0;
  endtask

  task automatic wr_busy(input logic mwe, input logic mv, input logic swe, input logic sv);
    m_bwe = mwe; m_bv = mv; s_bwe = swe; s_bv = sv;
    step();
    m_bwe = 0; s_bwe = 0;
  endtask

  task automatic clear_mon();
    n_rise = 0; n_fall = 0; n_hi = 0; n_irq_m = 0; n_irq_s = 0;
  endtask

  task automatic wait_idle(input bit both);
    for (int i = 0; i < 4000; i++) begin
      if (!m_busy && (!both || !s_busy)) break;
      step();
    end
    repeat (3) step();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog R5 actual=hung expected=done");
    summary();
    $finish;
  end

  // {rate, master byte, slave byte}
  localparam int NV = 6;
  localparam logic [17:0] VEC [NV] = '{
    {2'b00, 8'hA5, 8'h3C}, {2'b01, 8'h81, 8'h7E}, {2'b10, 8'hFF, 8'h00},
    {2'b11, 8'h00, 8'hFF}, {2'b00, 8'h5A, 8'hC3}, {2'b01, 8'h01, 8'h80}};

  initial begin
    repeat (3) step();
    // R1 reset state
    chk("R1 busy", m_busy, 0); chk("R1 sk", m_sk, 0); chk("R1 irq", m_irq, 0);
    chk("R1 rx", m_rx, 0); chk("R1 so_oe", m_so_oe, 0); chk("R1 sk_oe", m_sk_oe, 0);
    rst_n = 1; step();

    // R2 pin modes
    for (int k = 0; k < 8; k++) begin
      wr_cfg({k[2], k[1], k[0], 3'b000}, '0);
      chk("R2 so_oe", m_so_oe, k[2] & k[1]);
      chk("R2 sk_oe", m_sk_oe, k[2] & k[0]);
    end

    // vector table: full loopback exchanges (R3 R4 R5 R6 R8)
    for (int v = 0; v < NV; v++) begin
      logic [1:0] rt;
      logic [7:0] md, sd;
      int hf;
      {rt, md, sd} = VEC[v];
      hf = (rt == 2'b00) ? TC : (rt == 2'b01) ? 2 * TC : 4 * TC;
      wr_cfg({3'b111, rt, 1'b1}, {3'b110, 2'b00, 1'b1});
      load(md, sd);
      clear_mon();
      wr_busy(1, 1, 1, 1);
      wait_idle(1);
      chk("R4 master rx", m_rx, sd);
      chk("R8 slave rx", s_rx, md);
      chk("R5 pulses", n_rise, 8);
      chk("R3 high time", n_hi, 8 * hf);
      chk("R6 master irq", n_irq_m, 1);
      chk("R8 slave irq", n_irq_s, 1);
      chk("R5 busy clear", {m_busy, s_busy}, 0);
      chk("R4 idle low", m_sk, 0);
    end

    // R6 interrupt disabled
    wr_cfg({3'b111, 2'b00, 1'b0}, {3'b110, 2'b00, 1'b0});
    load(8'h96, 8'h69);
    clear_mon();
    wr_busy(1, 1, 1, 1);
    wait_idle(1);
    chk("R6 no irq", n_irq_m + n_irq_s, 0);
    chk("R6 data still moves", m_rx, 8'h69);

    // R7 abort after 3 bits
    wr_cfg({3'b111, 2'b00, 1'b1}, {3'b110, 2'b00, 1'b1});
    load(8'hB4, 8'h2D);
    clear_mon();
    wr_busy(1, 1, 1, 1);
    for (int i = 0; i < 500 && n_fall < 3; i++) step();
    wr_busy(1, 0, 0, 0);
    repeat (12) step();
    chk("R7 busy cleared", m_busy, 0);
    chk("R7 pulses", n_rise, 3);
    chk("R7 idle low", m_sk, 0);
    chk("R7 master partial", m_rx, {8'hB4 << 3} | (8'h2D >> 5));
    chk("R7 slave partial", s_rx, {8'h2D << 3} | (8'hB4 >> 5));
    chk("R7 slave waits", s_busy, 1);
    wr_busy(0, 0, 1, 0);
    repeat (3) step();
    chk("R7 no irq", n_irq_m + n_irq_s, 0);

    // R9 disabled slave ignores external clock
    wr_cfg({3'b111, 2'b00, 1'b0}, {3'b010, 2'b00, 1'b1});
    load(8'h11, 8'h5A);
    clear_mon();
    wr_busy(1, 1, 1, 1);
    wait_idle(0);
    chk("R9 pulses seen", n_rise, 8);
    chk("R9 slave holds", s_rx, 8'h5A);
    chk("R9 slave no oe", {s_so_oe, s_sk_oe}, 0);
    chk("R9 slave no irq", n_irq_s, 0);
    wr_busy(0, 0, 1, 0);

    summary();
    $finish;
  end
endmodule